// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block manages the power-down state of a small 8-bit processor core. When the core reports, with a single-cycle strobe, that it has just executed its sleep instruction, the controller turns the CPU clock enable off, clears the power-down status flag, sets the time-out status flag and asks the watchdog to clear its count. The oscillators and the watchdog counter are outside the block. Only their request and status lines reach it.

While the core sleeps, the controller watches two kinds of wake source. Reset-class sources are the external reset pin and brown-out detection, each gated by its own enable, plus power-on reset. They restart the clock and raise a device-reset request. Continuation-class sources are a watchdog time-out, an enabled external interrupt line and an enabled sleep-capable peripheral interrupt. They restart the clock without a reset. The core first runs the instruction it prefetched with the sleep instruction. The cycle after that, the block raises a vector request only if the global interrupt enable is set. The global enable never decides whether a wake happens. Every wake clears the watchdog, and the class of the most recent wake is held in a cause register.

If a wake condition is already present in the cycle the sleep strobe arrives, the clock is never gated. The sleep resolves at once as a wake of the matching class.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After a synchronous reset, the CPU clock enable is 1, the power-down flag is 1, the time-out flag is 1, the wake cause is 0 (none) and the wdt_clear, dev_reset, resume and vector outputs are 0.
- R2: A sleep strobe taken with no wake condition present drops the CPU clock enable in the next cycle. The enable stays low until a wake source is accepted.
- R3: The cycle after a sleep strobe, the power-down flag reads 0 and the time-out flag reads 1.
- R4: While asleep, the reset pin request with its enable set, the brown-out request with its enable set, or the power-on request each produce a one-cycle dev_reset pulse in the next cycle. The clock enable returns to 1 and the cause becomes 1 (reset).
- R5: A reset pin request or a brown-out request whose enable is 0 leaves the device asleep with no pulse.
- R6: While asleep, a watchdog time-out, an external interrupt line with its enable bit set, or a peripheral interrupt with its enable bit set produces a one-cycle resume pulse in the next cycle with the clock enable at 1. The cause becomes 2 (watchdog), 3 (external) or 4 (peripheral).
- R7: An interrupt flag whose individual enable is 0 does not wake the device. An enabled interrupt wakes it whether the global interrupt enable is 0 or 1.
- R8: The cycle after a resume pulse, vector is 1 if the global interrupt enable was 1 during the resume cycle, and 0 otherwise. A reset-class wake never produces a vector pulse.
- R9: wdt_clear pulses for one cycle on sleep entry and in the same cycle as every dev_reset or resume pulse.
- R10: When several sources are active together, reset-class wins over the watchdog, the watchdog wins over external interrupts, and external interrupts win over peripheral interrupts.
- R11: A sleep strobe that arrives while a wake condition is present never lowers the clock enable. In the next cycle it gives the dev_reset or resume pulse and the cause of that wake class, together with the R3 flag values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_exec_i | input | 1 | One-cycle strobe: sleep instruction executed |
| pin_rst_req_i | input | 1 | External reset pin request |
| pin_rst_en_i | input | 1 | External reset pin enable |
| bor_req_i | input | 1 | Brown-out reset request |
| bor_en_i | input | 1 | Brown-out reset enable |
| por_req_i | input | 1 | Power-on reset request |
| wdt_timeout_i | input | 1 | Watchdog time-out |
| ext_irq_flag_i | input | NEXT | External interrupt flags |
| ext_irq_en_i | input | NEXT | External interrupt individual enables |
| per_irq_flag_i | input | NPER | Sleep-capable peripheral interrupt flags |
| per_irq_en_i | input | NPER | Peripheral interrupt individual enables |
| gie_i | input | 1 | Global interrupt enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| pd_flag_o | output | 1 | Power-down status flag |
| to_flag_o | output | 1 | Time-out status flag |
| wdt_clear_o | output | 1 | Watchdog clear pulse |
| dev_reset_o | output | 1 | Device reset request pulse |
| resume_o | output | 1 | Resume pulse: run the prefetched instruction |
| vector_o | output | 1 | Vector-to-handler pulse |
| wake_cause_o | output | 3 | Class of the most recent wake |

## Verification
Two functions can land in the same cycle: sleep entry and wake acceptance. They collide when a source is already present as the sleep strobe arrives. The bench provokes this by raising the strobe together with a watchdog time-out, and again with a power-on request. It then expects the clock enable to stay at 1 with the sleep flags and the wake pulse in the next cycle. Sources of both classes are also raised in one cycle, and the result is judged by the single pulse and the recorded cause.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_STEP  = 2'd2
    } swc_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_RESET = 3'd1,
        CAUSE_WDT   = 3'd2,
        CAUSE_EXT   = 3'd3,
        CAUSE_PER   = 3'd4
    } wake_cause_e;

    typedef struct packed {
        logic        hit;
        logic        is_reset;
        wake_cause_e cause;
    } wake_req_t;

    // Fixed priority: reset class, then watchdog, external, peripheral.
    function automatic wake_req_t classify_wake(
        input logic rst_any,
        input logic wdt_any,
        input logic ext_any,
        input logic per_any
    );
        wake_req_t r;
        r.hit      = rst_any | wdt_any | ext_any | per_any;
        r.is_reset = rst_any;
        if (rst_any)      r.cause = CAUSE_RESET;
        else if (wdt_any) r.cause = CAUSE_WDT;
        else if (ext_any) r.cause = CAUSE_EXT;
        else if (per_any) r.cause = CAUSE_PER;
        else              r.cause = CAUSE_NONE;
        return r;
    endfunction

endpackage

// File: rtl/swc_wake_detect.sv
module swc_wake_detect
    import swc_pkg::*;
#(
    parameter int NEXT = 2,
    parameter int NPER = 4
) (
    input  logic            pin_rst_req_i,
    input  logic            pin_rst_en_i,
    input  logic            bor_req_i,
    input  logic            bor_en_i,
    input  logic            por_req_i,
    input  logic            wdt_timeout_i,
    input  logic [NEXT-1:0] ext_flag_i,
    input  logic [NEXT-1:0] ext_en_i,
    input  logic [NPER-1:0] per_flag_i,
    input  logic [NPER-1:0] per_en_i,
    output wake_req_t       req_o
);
    logic [NEXT-1:0] ext_live;
    logic [NPER-1:0] per_live;

    for (genvar i = 0; i < NEXT; i++) begin : g_ext
        assign ext_live[i] = ext_flag_i[i] & ext_en_i[i];
    end
    for (genvar j = 0; j < NPER; j++) begin : g_per
        assign per_live[j] = per_flag_i[j] & per_en_i[j];
    end

    logic rst_any;
    assign rst_any = (pin_rst_req_i & pin_rst_en_i) | (bor_req_i & bor_en_i) | por_req_i;

    assign req_o = classify_wake(rst_any, wdt_timeout_i, |ext_live, |per_live);
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
    import swc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_exec_i,
    input  wake_req_t req_i,
    input  logic      gie_i,
    output logic      sleep_take_o,
    output logic      wake_take_o,
    output logic      cpu_clk_en_o,
    output logic      wdt_clear_o,
    output logic      dev_reset_o,
    output logic      resume_o,
    output logic      vector_o
);
    swc_state_e st_q, st_d;

    assign sleep_take_o = (st_q == ST_RUN) && sleep_exec_i;
    assign wake_take_o  = req_i.hit && ((st_q == ST_SLEEP) || sleep_take_o);
    assign cpu_clk_en_o = (st_q != ST_SLEEP);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (sleep_take_o) st_d = req_i.hit ? (req_i.is_reset ? ST_RUN : ST_STEP) : ST_SLEEP;
            ST_SLEEP: if (req_i.hit)    st_d = req_i.is_reset ? ST_RUN : ST_STEP;
            ST_STEP:  st_d = ST_RUN;
            default:  st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_RUN;
            wdt_clear_o <= 1'b0;
            dev_reset_o <= 1'b0;
            resume_o    <= 1'b0;
            vector_o    <= 1'b0;
        end else begin
            st_q        <= st_d;
            wdt_clear_o <= sleep_take_o | wake_take_o;
            dev_reset_o <= wake_take_o & req_i.is_reset;
            resume_o    <= wake_take_o & ~req_i.is_reset;
            vector_o    <= (st_q == ST_STEP) & gie_i;
        end
    end

    a_r2_gate_after_sleep: assert property (@(posedge clk) disable iff (rst)
        (sleep_take_o && !req_i.hit) |=> !cpu_clk_en_o);
    a_r11_no_gate_when_pending: assert property (@(posedge clk) disable iff (rst)
        (sleep_take_o && req_i.hit) |=> cpu_clk_en_o);
    a_r9_clear_on_wake: assert property (@(posedge clk) disable iff (rst)
        (resume_o || dev_reset_o) |-> wdt_clear_o);
    a_r8_vector_follows_resume: assert property (@(posedge clk) disable iff (rst)
        vector_o |-> $past(resume_o));
    a_r4_reset_releases_clock: assert property (@(posedge clk) disable iff (rst)
        dev_reset_o |-> cpu_clk_en_o);
endmodule

// File: rtl/swc_status.sv
module swc_status
    import swc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sleep_take_i,
    input  logic        wake_take_i,
    input  wake_req_t   req_i,
    output logic        pd_o,
    output logic        to_o,
    output wake_cause_e cause_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pd_o    <= 1'b1;
            to_o    <= 1'b1;
            cause_o <= CAUSE_NONE;
        end else begin
            if (sleep_take_i) begin
                pd_o <= 1'b0;
                to_o <= 1'b1;
            end
            if (wake_take_i) cause_o <= req_i.cause;
        end
    end

    a_r3_flags_on_sleep: assert property (@(posedge clk) disable iff (rst)
        sleep_take_i |=> (!pd_o && to_o));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import swc_pkg::*;
#(
    parameter int NEXT = 2,
    parameter int NPER = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep_exec_i,
    input  logic            pin_rst_req_i,
    input  logic            pin_rst_en_i,
    input  logic            bor_req_i,
    input  logic            bor_en_i,
    input  logic            por_req_i,
    input  logic            wdt_timeout_i,
    input  logic [NEXT-1:0] ext_irq_flag_i,
    input  logic [NEXT-1:0] ext_irq_en_i,
    input  logic [NPER-1:0] per_irq_flag_i,
    input  logic [NPER-1:0] per_irq_en_i,
    input  logic            gie_i,
    output logic            cpu_clk_en_o,
    output logic            pd_flag_o,
    output logic            to_flag_o,
    output logic            wdt_clear_o,
    output logic            dev_reset_o,
    output logic            resume_o,
    output logic            vector_o,
    output logic [2:0]      wake_cause_o
);
    wake_req_t   req;
    logic        sleep_take, wake_take;
    wake_cause_e cause;

    swc_wake_detect #(.NEXT(NEXT), .NPER(NPER)) u_detect (
        .pin_rst_req_i(pin_rst_req_i),
        .pin_rst_en_i (pin_rst_en_i),
        .bor_req_i    (bor_req_i),
        .bor_en_i     (bor_en_i),
        .por_req_i    (por_req_i),
        .wdt_timeout_i(wdt_timeout_i),
        .ext_flag_i   (ext_irq_flag_i),
        .ext_en_i     (ext_irq_en_i),
        .per_flag_i   (per_irq_flag_i),
        .per_en_i     (per_irq_en_i),
        .req_o        (req)
    );

    swc_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sleep_exec_i(sleep_exec_i),
        .req_i       (req),
        .gie_i       (gie_i),
        .sleep_take_o(sleep_take),
        .wake_take_o (wake_take),
        .cpu_clk_en_o(cpu_clk_en_o),
        .wdt_clear_o (wdt_clear_o),
        .dev_reset_o (dev_reset_o),
        .resume_o    (resume_o),
        .vector_o    (vector_o)
    );

    swc_status u_status (
        .clk         (clk),
        .rst         (rst),
        .sleep_take_i(sleep_take),
        .wake_take_i (wake_take),
        .req_i       (req),
        .pd_o        (pd_flag_o),
        .to_o        (to_flag_o),
        .cause_o     (cause)
    );

    assign wake_cause_o = cause;

    a_r10_reset_cause_matches_pulse: assert property (@(posedge clk) disable iff (rst)
        dev_reset_o |-> (wake_cause_o == CAUSE_RESET));
    a_r6_resume_cause_is_irq: assert property (@(posedge clk) disable iff (rst)
        resume_o |-> (wake_cause_o != CAUSE_RESET && wake_cause_o != CAUSE_NONE));
endmodule

// File: tb/sleep_wake_ctrl_tb_top.sv
module sleep_wake_ctrl_tb_top;
    localparam int NEXT = 2;
    localparam int NPER = 4;

    logic clk = 1'b0;
    logic rst;
    logic sleep_exec, pin_rst_req, pin_rst_en, bor_req, bor_en, por_req, wdt_to, gie;
    logic [NEXT-1:0] ext_flag, ext_en;
    logic [NPER-1:0] per_flag, per_en;
    logic cpu_clk_en, pd_flag, to_flag, wdt_clear, dev_reset, resume, vector;
    logic [2:0] cause;

    always #2 clk = ~clk;

    sleep_wake_ctrl #(.NEXT(NEXT), .NPER(NPER)) dut_i (
        .clk(clk), .rst(rst), .sleep_exec_i(sleep_exec),
        .pin_rst_req_i(pin_rst_req), .pin_rst_en_i(pin_rst_en),
        .bor_req_i(bor_req), .bor_en_i(bor_en), .por_req_i(por_req),
        .wdt_timeout_i(wdt_to),
        .ext_irq_flag_i(ext_flag), .ext_irq_en_i(ext_en),
        .per_irq_flag_i(per_flag), .per_irq_en_i(per_en),
        .gie_i(gie),
        .cpu_clk_en_o(cpu_clk_en), .pd_flag_o(pd_flag), .to_flag_o(to_flag),
        .wdt_clear_o(wdt_clear), .dev_reset_o(dev_reset), .resume_o(resume),
        .vector_o(vector), .wake_cause_o(cause)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // src bits: 9 por, 8 pin, 7 pin_en, 6 bor, 5 bor_en, 4 wdt, 3 ext, 2 ext_en, 1 per, 0 per_en
    task automatic drive_src(input logic [9:0] s);
        por_req     = s[9];
        pin_rst_req = s[8];
        pin_rst_en  = s[7];
        bor_req     = s[6];
        bor_en      = s[5];
        wdt_to      = s[4];
        ext_flag    = {NEXT{s[3]}};
        ext_en      = {NEXT{s[2]}};
        per_flag    = {NPER{s[1]}};
        per_en      = {NPER{s[0]}};
    endtask

    // entry: {gie, src[9:0], woke, is_reset, cause[2:0]}
    localparam int NV = 13;
    localparam logic [15:0] TBL [NV] = '{
        {1'b1, 10'b0000001100, 1'b1, 1'b0, 3'd3},  // R6 ext, vector
        {1'b0, 10'b0000001100, 1'b1, 1'b0, 3'd3},  // R7 wakes with gie 0
        {1'b1, 10'b0000000011, 1'b1, 1'b0, 3'd4},  // R6 peripheral
        {1'b0, 10'b0000010000, 1'b1, 1'b0, 3'd2},  // R6 watchdog
        {1'b1, 10'b0110000000, 1'b1, 1'b1, 3'd1},  // R4 pin reset enabled
        {1'b1, 10'b0001100000, 1'b1, 1'b1, 3'd1},  // R4 brown-out enabled
        {1'b1, 10'b1000000000, 1'b1, 1'b1, 3'd1},  // R4 power-on
        {1'b1, 10'b0100000000, 1'b0, 1'b0, 3'd0},  // R5 pin disabled
        {1'b1, 10'b0001000000, 1'b0, 1'b0, 3'd0},  // R5 brown-out disabled
        {1'b1, 10'b0000001010, 1'b0, 1'b0, 3'd0},  // R7 flags without enables
        {1'b1, 10'b1000011111, 1'b1, 1'b1, 3'd1},  // R10 reset over all
        {1'b1, 10'b0000011111, 1'b1, 1'b0, 3'd2},  // R10 wdt over irqs
        {1'b1, 10'b0000001111, 1'b1, 1'b0, 3'd3}   // R10 ext over peripheral
    };

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sleep_exec = 1'b0; gie = 1'b0;
        drive_src(10'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 clk_en", cpu_clk_en, 1);
        chk("R1 pd", pd_flag, 1);
        chk("R1 to", to_flag, 1);
        chk("R1 cause", cause, 0);
        chk("R1 pulses", {wdt_clear, dev_reset, resume, vector}, 0);

        for (int k = 0; k < NV; k++) begin
            logic [15:0] e;
            logic exp_vec;
            e = TBL[k];
            gie = e[15];
            exp_vec = e[4] & ~e[3] & e[15];
            drive_src(10'b0);
            sleep_exec = 1'b1;
            @(negedge clk);
            sleep_exec = 1'b0;
            chk("R2 clock gated", cpu_clk_en, 0);
            chk("R3 pd cleared", pd_flag, 0);
            chk("R3 to set", to_flag, 1);
            chk("R9 clear on entry", wdt_clear, 1);
            @(negedge clk);
            chk("R2 still gated", cpu_clk_en, 0);
            drive_src(e[14:5]);
            @(negedge clk);
            drive_src(10'b0);
            if (e[4]) begin
                chk("R4/R6 clock back", cpu_clk_en, 1);
                chk("R4 dev_reset", dev_reset, int'(e[3]));
                chk("R6 resume", resume, int'(!e[3]));
                chk("R9 clear on wake", wdt_clear, 1);
                chk("R10 cause", cause, int'(e[2:0]));
                @(negedge clk);
                chk("R8 vector", vector, int'(exp_vec));
                chk("R4/R6 single pulse", {dev_reset, resume}, 0);
            end else begin
                chk("R5/R7 stays asleep", cpu_clk_en, 0);
                chk("R5/R7 no pulse", {dev_reset, resume, wdt_clear}, 0);
                wdt_to = 1'b1;
                @(negedge clk);
                wdt_to = 1'b0;
                chk("R6 recovery resume", resume, 1);
                @(negedge clk);
            end
            @(negedge clk);
        end

        // R11 sleep strobe with watchdog already pending
        gie = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        sleep_exec = 1'b1;
        wdt_to = 1'b1;
        chk("R11 clk before edge", cpu_clk_en, 1);
        @(negedge clk);
        sleep_exec = 1'b0;
        wdt_to = 1'b0;
        chk("R11 never gated", cpu_clk_en, 1);
        chk("R11 resume", resume, 1);
        chk("R11 wdt clear", wdt_clear, 1);
        chk("R11 cause", cause, 2);
        chk("R11 pd", pd_flag, 0);
        chk("R11 to", to_flag, 1);
        @(negedge clk);
        chk("R11 vector", vector, 1);
        chk("R11 still running", cpu_clk_en, 1);

        // R11 with power-on request pending
        @(negedge clk);
        sleep_exec = 1'b1;
        por_req = 1'b1;
        @(negedge clk);
        sleep_exec = 1'b0;
        por_req = 1'b0;
        chk("R11 reset never gated", cpu_clk_en, 1);
        chk("R11 dev_reset", dev_reset, 1);
        chk("R11 reset cause", cause, 1);
        @(negedge clk);
        chk("R11 no vector after reset", vector, 0);
        chk("R11 running", cpu_clk_en, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule